// File: doc/BRIEF.md
# ADC Serial Port Responder

This block imitates the digital side of a serial sampling converter. It is meant to sit opposite a converter controller, either as a partner in simulation or as a stand-in on a prototype board. The convert-start and serial-clock lines arrive already synchronous to the fast system clock. The block finds their rising edges and answers the way the real converter's digital port would. Each accepted convert start captures a parallel sample word from a stimulus port. The word already comes in two's complement form. The serial output then replays the word captured at the previous convert start, most significant bit first. A separate enable output models the three-state output pin.

The same two lines also control power. A run of convert-start edges with no serial-clock edge between them moves the block into a light power-down state, and a longer run moves it into a deep one. Any serial-clock edge brings the block back to active. When the deep state ends, the block raises a one-cycle wake event, so a bench can time its reference-settle wait from that point. The resolution is a parameter. At 12 bits, two zero filler bits pad the 16-clock window. At 14 bits, the data fills the window after two lead clocks.

Top module: `adc_port_responder`

## Requirements
- R1: After reset the block is active: `nap_o`, `sleep_o`, `wake_o`, `busy_o` and `sdo_oe_o` are all 0.
- R2: A convert rising edge while no frame is running latches `sample_i` and starts a frame. From the next cycle `busy_o` is 1 and `sdo_oe_o` is 0, and both lead serial-clock edges leave `sdo_oe_o` at 0.
- R3: On serial-clock rising edge k of a frame, for k from 3 to RES_W+2, `sdo_oe_o` is 1 and `sdo_o` carries bit RES_W+2-k of the frame word. The data goes out MSB first, one bit per rising edge, and is valid from the cycle after the edge.
- R4: The frame word is the sample latched at the previous accepted convert start. The first frame after reset sends all zeros.
- R5: With RES_W=12, edges 15 and 16 drive two filler bits of value 0 with `sdo_oe_o` at 1. With RES_W=14, edge 16 carries bit 0.
- R6: `busy_o` falls after the 16th serial-clock edge while the last bit stays driven. `sdo_oe_o` returns to 0 on the next serial-clock or accepted convert rising edge.
- R7: Convert rising edges while `busy_o` is 1 are ignored. The sample is not latched, the frame does not restart, and `sdo_o`/`sdo_oe_o` do not change.
- R8: Two convert rising edges with no serial-clock rising edge between them set `nap_o`. A serial-clock edge between them keeps the block active.
- R9: Four or more such convert edges set `sleep_o` and clear `nap_o`. Further convert edges keep the block in sleep.
- R10: Any serial-clock rising edge returns the block to active. `wake_o` pulses for exactly one cycle only when the state left was sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_i | input | 1 | Convert-start line, synchronous to clk |
| sck_i | input | 1 | Serial clock line, synchronous to clk |
| sample_i | input | RES_W | Two's complement sample word, latched on an accepted convert edge |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Output enable for the serial data (0 = high impedance) |
| busy_o | output | 1 | Frame in progress |
| nap_o | output | 1 | Light power-down state |
| sleep_o | output | 1 | Deep power-down state |
| wake_o | output | 1 | One-cycle pulse on exit from sleep |

## Verification
Several behaviours only show up when two events coincide within a frame: a convert edge arriving while a frame is still running, and the power counter climbing while that ignored frame is still pending. The stimulus produces both by sending extra convert pulses with fresh sample words, both in the middle of the data bits and right after a frame start. It then checks that the output bits continue unchanged and that the next frame still replays the older word. The wake pulse lasts a single cycle, so the bench samples it halfway through the serial-clock pulse that ends the sleep state. It repeats the same sequence from nap to show that no pulse appears there.

// File: rtl/adcr_pkg.sv
package adcr_pkg;

  localparam int FRAME_CLKS = 16;  // serial clocks per frame
  localparam int LEAD_CLKS  = 2;   // clocks before the first data bit
  localparam int NAP_EDGES  = 2;   // convert edges without sck to nap
  localparam int SLP_EDGES  = 4;   // convert edges without sck to sleep
  localparam int MAX_RES    = 16;
  localparam int IDX_W      = $clog2(MAX_RES);
  localparam int PCNT_W     = $clog2(SLP_EDGES + 1);

  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'd0,
    PWR_NAP    = 2'd1,
    PWR_SLEEP  = 2'd2
  } pwr_state_t;

  // True when clock position pos (1-based) drives a bit onto the line.
  function automatic logic in_data_window(input int pos);
    return (pos > LEAD_CLKS) && (pos <= FRAME_CLKS);
  endfunction

  // Bit sent at clock position pos: MSB first after the lead clocks,
  // zero filler once the word is exhausted.
  function automatic logic frame_bit(input logic [MAX_RES-1:0] word,
                                     input int res, input int pos);
    int idx;
    idx = pos - LEAD_CLKS - 1;
    if (idx < 0 || idx >= res) return 1'b0;
    return word[IDX_W'(res - 1 - idx)];
  endfunction

  // Power state from the count of consecutive convert edges.
  function automatic pwr_state_t pwr_decode(input logic [PCNT_W-1:0] n);
    if (int'(n) >= SLP_EDGES) return PWR_SLEEP;
    if (int'(n) >= NAP_EDGES) return PWR_NAP;
    return PWR_ACTIVE;
  endfunction

endpackage

// File: rtl/adcr_edge.sv
module adcr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/adcr_frame.sv
module adcr_frame
  import adcr_pkg::*;
#(
  parameter int RES_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_rise,
  input  logic             sck_rise,
  input  logic [RES_W-1:0] sample_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             busy_o
);
  localparam int CNT_W = $clog2(FRAME_CLKS + 1);

  logic [RES_W-1:0]   hold_q;   // sample captured at the latest start
  logic [RES_W-1:0]   word_q;   // word replayed in the current frame
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   cnt_n;
  logic [MAX_RES-1:0] word_pad;
  logic               busy_q, oe_q, sdo_q;
  logic               start, step;

  always_comb begin
    cnt_n    = cnt_q + 1'b1;
    start    = conv_rise && !busy_q;
    step     = sck_rise && busy_q && !start;
    word_pad = '0;
    word_pad[RES_W-1:0] = word_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      word_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      oe_q   <= 1'b0;
      sdo_q  <= 1'b0;
    end else if (start) begin
      hold_q <= sample_i;
      word_q <= hold_q;
      cnt_q  <= '0;
      busy_q <= 1'b1;
      oe_q   <= 1'b0;
    end else if (step) begin
      cnt_q  <= cnt_n;
      busy_q <= int'(cnt_n) < FRAME_CLKS;
      oe_q   <= in_data_window(int'(cnt_n));
      sdo_q  <= frame_bit(word_pad, RES_W, int'(cnt_n));
    end else if (sck_rise) begin
      oe_q   <= 1'b0;
    end
  end

  assign sdo_o    = sdo_q;
  assign sdo_oe_o = oe_q;
  assign busy_o   = busy_q;
endmodule

// File: rtl/adcr_power.sv
module adcr_power
  import adcr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic conv_rise,
  input  logic sck_rise,
  output logic nap_o,
  output logic sleep_o,
  output logic wake_o
);
  logic [PCNT_W-1:0] pcnt_q;
  logic              wake_q;
  pwr_state_t        state;

  always_comb state = pwr_decode(pcnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= sck_rise && (state == PWR_SLEEP);
      if (sck_rise)
        pcnt_q <= conv_rise ? PCNT_W'(1) : '0;
      else if (conv_rise && int'(pcnt_q) < SLP_EDGES)
        pcnt_q <= pcnt_q + 1'b1;
    end
  end

  assign nap_o   = (state == PWR_NAP);
  assign sleep_o = (state == PWR_SLEEP);
  assign wake_o  = wake_q;
endmodule

// File: rtl/adc_port_responder.sv
module adc_port_responder #(
  parameter int RES_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_i,
  input  logic             sck_i,
  input  logic [RES_W-1:0] sample_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             busy_o,
  output logic             nap_o,
  output logic             sleep_o,
  output logic             wake_o
);
  logic conv_rise;
  logic sck_rise;

  adcr_edge i_conv_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(conv_i), .rise_o(conv_rise)
  );

  adcr_edge i_sck_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(sck_i), .rise_o(sck_rise)
  );

  adcr_frame #(.RES_W(RES_W)) i_frame (
    .clk(clk), .rst_n(rst_n), .conv_rise(conv_rise), .sck_rise(sck_rise),
    .sample_i(sample_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .busy_o(busy_o)
  );

  adcr_power i_power (
    .clk(clk), .rst_n(rst_n), .conv_rise(conv_rise), .sck_rise(sck_rise),
    .nap_o(nap_o), .sleep_o(sleep_o), .wake_o(wake_o)
  );
endmodule

// File: rtl/adc_port_responder_chk.sv
module adc_port_responder_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_rise,
  input logic sck_rise,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic busy_o,
  input logic nap_o,
  input logic sleep_o,
  input logic wake_o
);
  AST_START_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    conv_rise && !busy_o |=> busy_o && !sdo_oe_o); // R2

  AST_OE_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe_o) |-> busy_o); // R3

  AST_TAIL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> sdo_oe_o); // R6

  AST_IGNORED_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    conv_rise && busy_o && !sck_rise |=> busy_o && $stable(sdo_oe_o) && $stable(sdo_o)); // R7

  AST_POWERDOWN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    conv_rise && !sck_rise && nap_o |=> nap_o || sleep_o); // R9

  AST_SCK_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> !nap_o && !sleep_o); // R10

  AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(sleep_o)); // R10
endmodule

bind adc_port_responder adc_port_responder_chk i_chk (
  .clk(clk), .rst_n(rst_n), .conv_rise(conv_rise), .sck_rise(sck_rise),
  .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .busy_o(busy_o), .nap_o(nap_o),
  .sleep_o(sleep_o), .wake_o(wake_o)
);

// File: tb/test_adc_port_responder.sv
module test_adc_port_responder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv = 1'b0;
  logic sck = 1'b0;
  logic [13:0] smp14 = '0;
  logic [11:0] smp12 = '0;
  logic sdo14, oe14, busy14, nap14, sleep14, wake14;
  logic sdo12, oe12, busy12, nap12, sleep12, wake12;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int prev14 = 0, prev12 = 0, exp14 = 0, exp12 = 0;
  logic mid_wake14, mid_wake12;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_port_responder #(.RES_W(14)) i_adc_port_responder (
    .clk(clk), .rst_n(rst_n), .conv_i(conv), .sck_i(sck), .sample_i(smp14),
    .sdo_o(sdo14), .sdo_oe_o(oe14), .busy_o(busy14), .nap_o(nap14),
    .sleep_o(sleep14), .wake_o(wake14)
  );

  adc_port_responder #(.RES_W(12)) i_adc_port_responder_r12 (
    .clk(clk), .rst_n(rst_n), .conv_i(conv), .sck_i(sck), .sample_i(smp12),
    .sdo_o(sdo12), .sdo_oe_o(oe12), .busy_o(busy12), .nap_o(nap12),
    .sleep_o(sleep12), .wake_o(wake12)
  );

  function automatic int ref_bit(input int word, input int res, input int k);
    int i;
    i = k - 3;
    if (i < 0 || i >= res) return 0;
    return (word >> (res - 1 - i)) & 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic conv_pulse(input int a, input int b);
    smp14 = 14'(a);
    smp12 = 12'(b);
    conv = 1'b1;
    @(negedge clk);
    conv = 1'b0;
    @(negedge clk);
  endtask

  task automatic accept_conv(input int a, input int b);
    conv_pulse(a, b);
    exp14 = prev14; prev14 = a & 'h3FFF;
    exp12 = prev12; prev12 = b & 'hFFF;
  endtask

  task automatic sck_pulse();
    sck = 1'b1;
    @(negedge clk);
    mid_wake14 = wake14;
    mid_wake12 = wake12;
    sck = 1'b0;
    @(negedge clk);
  endtask

  task automatic clock_bits(input int from_k, input int to_k, input string tag);
    for (int k = from_k; k <= to_k; k++) begin
      sck_pulse();
      check({tag, " oe14"}, int'(oe14), (k >= 3) ? 1 : 0);
      check({(k >= 15) ? "R5" : tag, " oe12"}, int'(oe12), (k >= 3) ? 1 : 0);
      if (k >= 3) begin
        check({tag, " sdo14"}, int'(sdo14), ref_bit(exp14, 14, k));
        check({(k >= 15) ? "R5" : tag, " sdo12"}, int'(sdo12), ref_bit(exp12, 12, k));
      end
      check("R6 busy", int'(busy14), (k < 16) ? 1 : 0);
      check("R6 busy12", int'(busy12), (k < 16) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 oe", int'(oe14 | oe12), 0);
    check("R1 busy", int'(busy14 | busy12), 0);
    check("R1 nap", int'(nap14 | nap12), 0);
    check("R1 sleep", int'(sleep14 | sleep12), 0);
    check("R1 wake", int'(wake14 | wake12), 0);

    for (int f = 0; f < 20; f++) begin
      int s14, s12;
      case (f)
        1: s14 = 'h3FFF;
        2: s14 = 'h2000;
        3: s14 = 'h1FFF;
        4: s14 = 0;
        default: s14 = ((f * 7451) ^ (f << 9)) & 'h3FFF;
      endcase
      s12 = (s14 ^ (f * 'h5A5)) & 'hFFF;
      if (f == 2) s12 = 'hFFF;
      accept_conv(s14, s12);
      check("R2 busy", int'(busy14 & busy12), 1);
      check("R2 oe off at start", int'(oe14 | oe12), 0);
      if (f == 5) begin
        clock_bits(1, 5, "R3");
        conv_pulse('h1555, 'hAAA);   // ignored: frame running
        check("R7 busy", int'(busy14 & busy12), 1);
        check("R7 oe", int'(oe14 & oe12), 1);
        check("R7 sdo14", int'(sdo14), ref_bit(exp14, 14, 5));
        check("R7 sdo12", int'(sdo12), ref_bit(exp12, 12, 5));
        clock_bits(6, 16, "R7");
      end else begin
        clock_bits(1, 16, (f == 0) ? "R4" : "R3");
      end
      repeat (3) @(negedge clk);
      check("R6 tail oe", int'(oe14 & oe12), 1);
      check("R6 tail sdo14", int'(sdo14), exp14 & 1);
      check("R6 tail sdo12", int'(sdo12), 0);
      if (f % 2 == 1) begin
        sck_pulse();
        check("R6 hi-z after extra sck", int'(oe14 | oe12), 0);
        check("R6 still idle", int'(busy14 | busy12), 0);
      end
    end

    // power modes: edges from sleep
    accept_conv('h0ABC, 'h123);
    check("R8 one edge stays active", int'(nap14 | sleep14), 0);
    conv_pulse('h3333, 'h333);
    check("R8 nap", int'(nap14 & nap12), 1);
    check("R8 not sleep", int'(sleep14), 0);
    conv_pulse('h3333, 'h333);
    check("R8 nap at three", int'(nap14), 1);
    conv_pulse('h3333, 'h333);
    check("R9 sleep", int'(sleep14 & sleep12), 1);
    check("R9 nap cleared", int'(nap14), 0);
    conv_pulse('h3333, 'h333);
    check("R9 sleep saturates", int'(sleep14), 1);
    sck_pulse();
    check("R10 wake pulse", int'(mid_wake14 & mid_wake12), 1);
    check("R10 wake one cycle", int'(wake14 | wake12), 0);
    check("R10 active", int'(sleep14 | nap14 | sleep12 | nap12), 0);
    clock_bits(2, 16, "R7");

    // nap exit gives no wake pulse
    accept_conv('h2468, 'h864);
    conv_pulse('h1111, 'h111);
    check("R8 nap again", int'(nap14), 1);
    sck_pulse();
    check("R10 no wake from nap", int'(mid_wake14 | mid_wake12), 0);
    check("R10 nap cleared", int'(nap14 | nap12), 0);
    clock_bits(2, 16, "R3");

    // sck between convert edges keeps active
    accept_conv('h0F0F, 'hF0F);
    sck_pulse();
    conv_pulse('h1111, 'h111);
    check("R8 interleaved sck no nap", int'(nap14 | nap12), 0);
    clock_bits(2, 16, "R3");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule